// File: doc/BRIEF.md
# DDR SDRAM Refresh Command Sequencer

This block sits in a DDR SDRAM controller and produces the command-bus traffic needed to keep the memory refreshed. It has three request inputs: a periodic auto-refresh request, a request to put the device into self refresh, and a request to bring it back out. A request is a one-cycle pulse. A request that arrives while a sequence is already running is held and is started the next time the sequencer is idle. The controller reports which banks are open through a bitmap. The sequencer precharges those banks before any refresh. It then issues the refresh command and holds the bus at NOP, with the clock enable high, for the refresh cycle time.

For self refresh, the sequencer precharges the open banks and then enters self refresh. Entry is the refresh command encoding with the clock enable driven low in the same cycle. The device stays there until an exit has been requested and the controller reports that the clock is stable. On exit, the clock enable goes high and NOPs cover the exit-to-command window. A mode-register load to the base mode register then resets the DLL. Reads stay blocked until the DLL relock window has run out. Two outputs report this to the controller: `cmd_allowed` says whether non-read commands may be issued, and `read_allowed` says whether a READ may be issued. All request, status and command pins are plain level signals with no handshake.

Top module: `ddr_refresh_seq`

## Requirements
- R1: After reset, the bus carries NOP, `cke` is 1, `busy` is 0, and both `cmd_allowed` and `read_allowed` are 1. Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000.
- R2: A request taken from idle with any bank open starts with one PRECHARGE in the next cycle. If two or more banks are open, `addr[10]`=1 and `ba`=0. If exactly one bank is open, `addr[10]`=0 and `ba` is the index of that bank. If no bank is open, the PRECHARGE is skipped and the refresh or entry command comes first.
- R3: The AUTO REFRESH (or self-refresh entry) command follows the PRECHARGE T_RP cycles later, with NOP in between.
- R4: After each AUTO REFRESH, the bus carries only NOP for T_RFC-1 cycles. The sequencer is then idle.
- R5: `cke` stays 1 from the AUTO REFRESH cycle through the whole T_RFC window.
- R6: An auto-refresh request that arrives during a running sequence is held. After the current sequence ends and one idle cycle passes, a second AUTO REFRESH is issued with its own T_RFC wait.
- R7: Self-refresh entry drives the AUTO REFRESH encoding with `cke`=0. Afterwards `cke` stays 0 and the bus is NOP. `read_allowed` and `cmd_allowed` are both 0 from the entry cycle onward.
- R8: Self refresh is left only when an exit has been requested (a held pulse counts) and `clk_stable` is 1. An exit request made outside self refresh has no effect.
- R9: After `cke` rises, the bus is NOP with `cmd_allowed`=0 for T_XSNR cycles.
- R10: T_XSNR cycles after `cke` rises, one LOAD MODE is issued with `ba`=0 and `addr`=MODE_BASE with bit 8 (DLL reset) set. In that cycle `cmd_allowed` is 1 and `busy` is 1.
- R11: `read_allowed` stays 0 until exactly T_DLL cycles after the LOAD MODE cycle, and then goes to 1.
- R12: `busy` is 1 in every cycle in which a sequence is active, and 0 when the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_req | input | 1 | Auto-refresh request pulse |
| sr_enter_req | input | 1 | Self-refresh entry request pulse |
| sr_exit_req | input | 1 | Self-refresh exit request pulse |
| clk_stable | input | 1 | Memory clock is stable, so exit is permitted |
| banks_open | input | NB | Bitmap of open banks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | AW | Address bus; bit 10 selects precharge of all banks |
| cke | output | 1 | Clock enable |
| busy | output | 1 | A sequence is in progress |
| cmd_allowed | output | 1 | Non-read commands are permitted |
| read_allowed | output | 1 | READ is permitted |

## Verification
The bench sweeps the auto-refresh sequence over all sixteen bank bitmaps of a four-bank configuration. This separates three cases: the precharge being skipped, a single-bank precharge with the right bank index, and an all-bank precharge. The self-refresh sequence is run over the same sixteen bitmaps, so entry with and without a preceding precharge is covered. In each run the exit request arrives while the clock is not yet stable, which shows that the exit is held back until `clk_stable` is set. A second refresh request is injected during a refresh wait to show it is held and served with its own wait. A stray exit request while idle shows that such requests are ignored.

// File: rtl/ddr_rfsh_pkg.sv
package ddr_rfsh_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRFC,
    ST_SRE,
    ST_SELF,
    ST_XSNR,
    ST_DLLRST
  } rfsh_state_e;

  localparam int unsigned DLL_RST_BIT = 8;
  localparam int unsigned ALL_BANK_BIT = 10;

endpackage

// File: rtl/rfsh_req_latch.sv
module rfsh_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic en,
  input  logic take,
  output logic want
);

  logic pend_q;

  assign want = pend_q | (req & en);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q | (req & en)) & ~take;
  end

endmodule

// File: rtl/rfsh_bank_decode.sv
module rfsh_bank_decode #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic [NB-1:0]   open_mask,
  output logic            need_pre,
  output logic            pre_all,
  output logic [BA_W-1:0] bank
);

  always_comb begin
    bank = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (open_mask[i]) bank = BA_W'(i);
    end
  end

  assign need_pre = |open_mask;
  assign pre_all  = ($countones(open_mask) > 1);

endmodule

// File: rtl/rfsh_wait_cnt.sv
module rfsh_wait_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import ddr_rfsh_pkg::*;
#(
  parameter int NB        = 4,
  parameter int AW        = 13,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 42,
  parameter int T_XSNR    = 45,
  parameter int T_DLL     = 200,
  parameter int MODE_BASE = 'h062,
  localparam int BA_W     = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ar_req,
  input  logic            sr_enter_req,
  input  logic            sr_exit_req,
  input  logic            clk_stable,
  input  logic [NB-1:0]   banks_open,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [BA_W-1:0] ba,
  output logic [AW-1:0]   addr,
  output logic            cke,
  output logic            busy,
  output logic            cmd_allowed,
  output logic            read_allowed
);

  localparam int MAX_A    = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int MAX_WAIT = (MAX_A > T_XSNR) ? MAX_A : T_XSNR;
  localparam int CW       = $clog2(MAX_WAIT + 1);
  localparam int LW       = $clog2(T_DLL + 1);
  localparam logic [AW-1:0] DLL_WORD =
    AW'(MODE_BASE) | (AW'(1) << DLL_RST_BIT);

  rfsh_state_e state_q, state_d;
  logic        goal_sr_q, goal_sr_d;
  logic        pre_all_q, pre_all_d;
  logic [BA_W-1:0] ba_q, ba_d;

  logic ar_want, sr_want, exit_want;
  logic take_ar, take_sr, take_exit;
  logic dec_need, dec_all;
  logic [BA_W-1:0] dec_bank;
  logic wait_load, wait_done;
  logic [CW-1:0] wait_val;
  logic lock_load, lock_done;
  logic in_sr_span;
  ddr_cmd_e cmd;

  rfsh_req_latch u_ar_latch (
    .clk(clk), .rst_n(rst_n), .req(ar_req), .en(1'b1),
    .take(take_ar), .want(ar_want)
  );

  rfsh_req_latch u_sre_latch (
    .clk(clk), .rst_n(rst_n), .req(sr_enter_req), .en(1'b1),
    .take(take_sr), .want(sr_want)
  );

  rfsh_req_latch u_srx_latch (
    .clk(clk), .rst_n(rst_n), .req(sr_exit_req), .en(state_q == ST_SELF),
    .take(take_exit), .want(exit_want)
  );

  rfsh_bank_decode #(.NB(NB), .BA_W(BA_W)) u_dec (
    .open_mask(banks_open), .need_pre(dec_need),
    .pre_all(dec_all), .bank(dec_bank)
  );

  rfsh_wait_cnt #(.W(CW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_load),
    .load_val(wait_val), .done(wait_done)
  );

  rfsh_wait_cnt #(.W(LW)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load),
    .load_val(LW'(T_DLL - 1)), .done(lock_done)
  );

  always_comb begin
    state_d   = state_q;
    goal_sr_d = goal_sr_q;
    pre_all_d = pre_all_q;
    ba_d      = ba_q;
    take_ar   = 1'b0;
    take_sr   = 1'b0;
    take_exit = 1'b0;
    wait_load = 1'b0;
    wait_val  = '0;
    lock_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ar_want || sr_want) begin
          take_ar   = ar_want;
          take_sr   = !ar_want;
          goal_sr_d = !ar_want;
          pre_all_d = dec_all;
          ba_d      = dec_bank;
          if (dec_need)     state_d = ST_PRE;
          else if (ar_want) state_d = ST_REF;
          else              state_d = ST_SRE;
        end
      end
      ST_PRE: begin
        wait_load = 1'b1;
        wait_val  = CW'(T_RP - 2);
        state_d   = ST_TRP;
      end
      ST_TRP: begin
        if (wait_done) state_d = goal_sr_q ? ST_SRE : ST_REF;
      end
      ST_REF: begin
        wait_load = 1'b1;
        wait_val  = CW'(T_RFC - 2);
        state_d   = ST_TRFC;
      end
      ST_TRFC: begin
        if (wait_done) state_d = ST_IDLE;
      end
      ST_SRE: state_d = ST_SELF;
      ST_SELF: begin
        if (exit_want && clk_stable) begin
          take_exit = 1'b1;
          wait_load = 1'b1;
          wait_val  = CW'(T_XSNR - 1);
          state_d   = ST_XSNR;
        end
      end
      ST_XSNR: begin
        if (wait_done) state_d = ST_DLLRST;
      end
      ST_DLLRST: begin
        lock_load = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      goal_sr_q <= 1'b0;
      pre_all_q <= 1'b0;
      ba_q      <= '0;
    end else begin
      state_q   <= state_d;
      goal_sr_q <= goal_sr_d;
      pre_all_q <= pre_all_d;
      ba_q      <= ba_d;
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    cke  = 1'b1;
    unique case (state_q)
      ST_PRE: begin
        cmd = CMD_PRE;
        addr[ALL_BANK_BIT] = pre_all_q;
        ba  = pre_all_q ? '0 : ba_q;
      end
      ST_REF:    cmd = CMD_REF;
      ST_SRE: begin
        cmd = CMD_REF;
        cke = 1'b0;
      end
      ST_SELF:   cke = 1'b0;
      ST_DLLRST: begin
        cmd  = CMD_LMR;
        addr = DLL_WORD;
      end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  assign in_sr_span   = (state_q == ST_SRE) || (state_q == ST_SELF) ||
                        (state_q == ST_XSNR);
  assign busy         = (state_q != ST_IDLE);
  assign cmd_allowed  = !in_sr_span;
  assign read_allowed = lock_done && !in_sr_span && (state_q != ST_DLLRST);

endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int NB        = 4,
  parameter int AW        = 13,
  parameter int T_RFC     = 42,
  parameter int T_DLL     = 200,
  parameter int MODE_BASE = 'h062,
  parameter int BA_W      = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_stable,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic [AW-1:0]   addr,
  input logic            cke,
  input logic            busy,
  input logic            cmd_allowed,
  input logic            read_allowed
);

  logic [3:0]  cmd;
  logic [31:0] rfc_left, lock_left;
  logic [AW-1:0] dll_word;

  assign cmd      = {cs_n, ras_n, cas_n, we_n};
  assign dll_word = AW'(MODE_BASE) | (AW'(1) << 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rfc_left  <= '0;
      lock_left <= '0;
    end else begin
      if (cmd == 4'b0001 && cke)  rfc_left <= 32'(T_RFC - 1);
      else if (rfc_left != 0)     rfc_left <= rfc_left - 1;
      if (cmd == 4'b0000)         lock_left <= 32'(T_DLL - 1);
      else if (lock_left != 0)    lock_left <= lock_left - 1;
    end
  end

  // R4
  rfc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfc_left != 0) |-> (cmd == 4'b0111));

  // R5
  rfc_cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfc_left != 0) |-> cke);

  // R7
  sr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!read_allowed && !cmd_allowed));

  // R7
  sr_entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == 4'b0001));

  // R8
  sr_exit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));

  // R9
  sr_exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd == 4'b0111 && !cmd_allowed));

  // R10
  dll_rst_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (ba == '0 && addr == dll_word && cmd_allowed));

  // R11
  dll_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_left != 0) |-> !read_allowed);

  // R12
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |-> busy);

endmodule

bind ddr_refresh_seq rfsh_seq_chk #(
  .NB(NB), .AW(AW), .T_RFC(T_RFC), .T_DLL(T_DLL),
  .MODE_BASE(MODE_BASE), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .cke(cke), .busy(busy),
  .cmd_allowed(cmd_allowed), .read_allowed(read_allowed)
);

// File: tb/ddr_refresh_seq_tb.sv
`timescale 1ns/1ps
module ddr_refresh_seq_tb;

  localparam int NB        = 4;
  localparam int AW        = 13;
  localparam int T_RP      = 3;
  localparam int T_RFC     = 5;
  localparam int T_XSNR    = 4;
  localparam int T_DLL     = 12;
  localparam int MODE_BASE = 'h032;
  localparam int BA_W      = 2;
  localparam int NOP = 7, PRE = 2, REF = 1, LMR = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ar_req = 0, sr_enter_req = 0, sr_exit_req = 0, clk_stable = 0;
  logic [NB-1:0] banks_open = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, busy, cmd_allowed, read_allowed;
  logic [BA_W-1:0] ba;
  logic [AW-1:0] addr;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ddr_refresh_seq #(
    .NB(NB), .AW(AW), .T_RP(T_RP), .T_RFC(T_RFC), .T_XSNR(T_XSNR),
    .T_DLL(T_DLL), .MODE_BASE(MODE_BASE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ar_req(ar_req), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .clk_stable(clk_stable), .banks_open(banks_open),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .cke(cke), .busy(busy), .cmd_allowed(cmd_allowed),
    .read_allowed(read_allowed)
  );

  function automatic int cmd_now();
    return int'({cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Precharge phase common to both sequences; first sample already taken.
  task automatic expect_pre(input int mask, input string rq);
    int ones = 0;
    int low = 0;
    for (int i = NB - 1; i >= 0; i--) if (mask[i]) begin ones++; low = i; end
    chk({rq, " R2 precharge cmd"}, cmd_now(), PRE);
    chk({rq, " R2 all-bank flag"}, int'(addr[10]), (ones > 1) ? 1 : 0);
    chk({rq, " R2 bank"}, int'(ba), (ones > 1) ? 0 : low);
    for (int k = 1; k < T_RP; k++) begin
      @(negedge clk);
      chk({rq, " R3 nop after precharge"}, cmd_now(), NOP);
    end
    @(negedge clk);
  endtask

  task automatic run_ar(input int mask);
    banks_open = NB'(mask);
    @(negedge clk); ar_req = 1;
    @(negedge clk); ar_req = 0;
    if (mask != 0) expect_pre(mask, "AR");
    chk("R3 refresh cmd", cmd_now(), REF);
    chk("R5 cke at refresh", int'(cke), 1);
    chk("R12 busy at refresh", int'(busy), 1);
    banks_open = '0;
    for (int k = 1; k < T_RFC; k++) begin
      @(negedge clk);
      chk("R4 nop in trfc", cmd_now(), NOP);
      chk("R5 cke in trfc", int'(cke), 1);
    end
    @(negedge clk);
    chk("R12 idle after trfc", int'(busy), 0);
  endtask

  task automatic run_sr(input int mask);
    clk_stable = 0;
    banks_open = NB'(mask);
    @(negedge clk); sr_enter_req = 1;
    @(negedge clk); sr_enter_req = 0;
    if (mask != 0) expect_pre(mask, "SR");
    banks_open = '0;
    chk("R7 entry cmd", cmd_now(), REF);
    chk("R7 entry cke", int'(cke), 0);
    chk("R7 entry read_allowed", int'(read_allowed), 0);
    chk("R7 entry cmd_allowed", int'(cmd_allowed), 0);
    @(negedge clk);
    sr_exit_req = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sr_exit_req = 0;
      chk("R8 held without clk_stable", int'(cke), 0);
      chk("R7 nop in self refresh", cmd_now(), NOP);
    end
    clk_stable = 1;
    for (int k = 0; k < T_XSNR; k++) begin
      @(negedge clk);
      chk("R9 cke high after exit", int'(cke), 1);
      chk("R9 nop in txsnr", cmd_now(), NOP);
      chk("R9 cmd_allowed low", int'(cmd_allowed), 0);
    end
    @(negedge clk);
    chk("R10 dll reset cmd", cmd_now(), LMR);
    chk("R10 dll reset ba", int'(ba), 0);
    chk("R10 dll reset word", int'(addr), MODE_BASE | 256);
    chk("R10 cmd_allowed", int'(cmd_allowed), 1);
    chk("R10 busy", int'(busy), 1);
    for (int k = 1; k <= T_DLL; k++) begin
      @(negedge clk);
      chk("R11 read lockout", int'(read_allowed), (k == T_DLL) ? 1 : 0);
    end
    clk_stable = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cmd", cmd_now(), NOP);
    chk("R1 reset cke", int'(cke), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset cmd_allowed", int'(cmd_allowed), 1);
    chk("R1 reset read_allowed", int'(read_allowed), 1);

    for (int m = 0; m < (1 << NB); m++) run_ar(m);

    // R6: second request arrives during the refresh wait
    banks_open = '0;
    @(negedge clk); ar_req = 1;
    @(negedge clk); ar_req = 0;
    chk("R6 first refresh", cmd_now(), REF);
    for (int k = 1; k < T_RFC; k++) begin
      @(negedge clk);
      ar_req = (k == 1);
      chk("R6 nop in first trfc", cmd_now(), NOP);
    end
    ar_req = 0;
    @(negedge clk);
    chk("R6 idle gap", int'(busy), 0);
    @(negedge clk);
    chk("R6 second refresh", cmd_now(), REF);
    for (int k = 1; k < T_RFC; k++) begin
      @(negedge clk);
      chk("R6 nop in second trfc", cmd_now(), NOP);
    end
    @(negedge clk);
    chk("R6 idle after second", int'(busy), 0);

    // R8: exit request while not in self refresh is ignored
    clk_stable = 1;
    @(negedge clk); sr_exit_req = 1;
    @(negedge clk); sr_exit_req = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R8 stray exit cke", int'(cke), 1);
      chk("R8 stray exit busy", int'(busy), 0);
      chk("R8 stray exit cmd", cmd_now(), NOP);
      @(negedge clk);
    end

    for (int m = 0; m < (1 << NB); m++) run_sr(m);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule